// File: doc/BRIEF.md
# Ultra DMA Receive Word Packer

This block is the receive end of a DMA data pipeline that sits between a storage device and a block cipher. A transfer opens with a short handshake: the controller arms the block with `start`, the device raises its request line, and the block answers by raising its acknowledge. From then on the device paces the data itself. Every change of level on its DMA strobe, rising or falling, marks one valid 16-bit word on the data bus. The strobe is assumed to be already synchronised to the core clock.

Each captured word is folded into a running 16-bit receive CRC. The words are also packed, eight at a time, into a 128-bit block for the downstream cipher. The block leaves through a valid/ready output. The device strobe cannot be paused, so back-pressure cannot reach the bus. Instead, a finished block waits in a single holding register until the cipher accepts it, and a block that completes while the previous one is still unaccepted is reported as an overrun.

When the controller signals the end of the transfer with `stop`, the block shows the final CRC so that the sender's checksum can be compared against it. It also flags a transfer whose word count was not a whole number of blocks.

Top module: `udma_rx_packer`

## Requirements
- R1: After `start` is accepted, `host_ack` stays low until `dev_req` has been seen high on a clock edge. `host_ack` then rises on the next cycle and stays high until `stop`. `start` is accepted only while no transfer is in progress.
- R2: While `host_ack` is high, each clock edge at which `strobe` differs from its level on the previous edge captures `data_in` as one word. Rising and falling changes are treated alike. A strobe change in the same cycle as `stop` is not captured.
- R3: The CRC is seeded with 0x4ABA when `start` is accepted. For each captured word it steps bit by bit, most significant data bit first: the feedback is crc[15] XOR d, the register shifts left by one, and it is XORed with 0x1021 when the feedback is 1. `crc_valid` goes high the cycle after `stop`, and `crc_out` then holds the final value.
- R4: Eight captured words form one block. The first word of a block sits in bits [127:112] and the eighth word in bits [15:0].
- R5: `blk_valid` rises in the cycle after the eighth word of a block is captured. While `blk_ready` is low it stays high with `blk_data` unchanged. A block is accepted on a clock edge where both `blk_valid` and `blk_ready` are high, so with `blk_ready` held high the pulse lasts one cycle.
- R6: If a block completes while the previous block is still unaccepted, `err_overrun` goes high and stays high until the next accepted `start`. The new block replaces the old one, and `blk_valid` stays high.
- R7: On `stop`, `err_partial` is set if the number of captured words is not a multiple of eight, and cleared otherwise. `start` also clears it.
- R8: Strobe changes while `host_ack` is low capture nothing. They change neither the CRC nor the block output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Arms a new transfer (pulse) |
| stop | input | 1 | Ends the current transfer (pulse) |
| dev_req | input | 1 | DMA request from the sending device |
| host_ack | output | 1 | DMA acknowledge; high while words are being captured |
| strobe | input | 1 | Synchronised device strobe; each level change marks a word |
| data_in | input | 16 | Device data bus |
| blk_valid | output | 1 | A 128-bit block is available |
| blk_ready | input | 1 | The downstream cipher accepts the block |
| blk_data | output | 128 | Packed block, first word in the top bits |
| crc_out | output | 16 | Running receive CRC; final value once `crc_valid` is high |
| crc_valid | output | 1 | Transfer ended; `crc_out` is final |
| err_partial | output | 1 | The last transfer ended mid-block |
| err_overrun | output | 1 | A block was overwritten before it was accepted |

## Verification
A missed or doubled strobe edge moves every later word by one place. It therefore shows up in the very next `blk_data`, at most eight words later, and it also corrupts `crc_out` and `err_partial` at the end of the transfer. A wrong CRC bit order or seed shows only in `crc_out` once `crc_valid` rises, so every transfer, including one with no words at all, is checked at its end. A wrong hold condition on the output register shows while `blk_ready` is low, as a dropped `blk_valid` or a changed `blk_data` in the cycles before acceptance.

// File: rtl/udma_rx_pkg.sv
`timescale 1ns/1ps
package udma_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2,
    ST_DONE = 2'd3
  } rx_state_e;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'h4ABA;
endpackage

// File: rtl/udma_rx_edge.sv
`timescale 1ns/1ps
module udma_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic toggled
);
  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end

  assign toggled = strobe ^ strobe_q;
endmodule

// File: rtl/udma_rx_crc.sv
`timescale 1ns/1ps
module udma_rx_crc #(
  parameter int           WORD_W = 16,
  parameter int           CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] SEED = 16'h4ABA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              sample,
  input  logic [WORD_W-1:0] word,
  output logic [CRC_W-1:0]  crc
);
  logic [CRC_W-1:0] crc_nx;

  always_comb begin
    logic fb;
    crc_nx = crc;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb     = crc_nx[CRC_W-1] ^ word[i];
      crc_nx = {crc_nx[CRC_W-2:0], 1'b0};
      if (fb) crc_nx = crc_nx ^ POLY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc <= SEED;
    else if (init)   crc <= SEED;
    else if (sample) crc <= crc_nx;
  end

  // R3
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !sample) |=> $stable(crc));
endmodule

// File: rtl/udma_rx_pack.sv
`timescale 1ns/1ps
module udma_rx_pack #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     sample,
  input  logic [WORD_W-1:0]        word,
  input  logic                     out_ready,
  output logic                     out_valid,
  output logic [WORD_W*WORDS-1:0]  out_data,
  output logic                     mid_block,
  output logic                     overrun
);
  localparam int CW    = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int BLK_W = WORD_W * WORDS;
  localparam int BUF_W = BLK_W - WORD_W;

  logic [BUF_W-1:0] sbuf;
  logic [CW-1:0]    cnt;
  logic             last;

  assign last      = sample && (cnt == CW'(WORDS - 1));
  assign mid_block = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sbuf      <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      overrun   <= 1'b0;
    end else if (clear) begin
      cnt     <= '0;
      overrun <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
    end else begin
      if (sample) begin
        sbuf <= BUF_W'({sbuf, word});
        cnt  <= last ? '0 : cnt + CW'(1);
      end
      if (last) begin
        out_data  <= {sbuf, word};
        out_valid <= 1'b1;
        if (out_valid && !out_ready) overrun <= 1'b1;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R5
  hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !last) |=> (out_valid && $stable(out_data)));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !clear) |=> (cnt != $past(cnt)));

  // R6
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !clear) |=> overrun);
endmodule

// File: rtl/udma_rx_packer.sv
`timescale 1ns/1ps
module udma_rx_packer
  import udma_rx_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int WORDS  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    stop,
  input  logic                    dev_req,
  output logic                    host_ack,
  input  logic                    strobe,
  input  logic [WORD_W-1:0]       data_in,
  output logic                    blk_valid,
  input  logic                    blk_ready,
  output logic [WORD_W*WORDS-1:0] blk_data,
  output logic [15:0]             crc_out,
  output logic                    crc_valid,
  output logic                    err_partial,
  output logic                    err_overrun
);
  rx_state_e state;
  logic      toggled;
  logic      sample;
  logic      arm;
  logic      mid_block;

  assign arm      = start && ((state == ST_IDLE) || (state == ST_DONE));
  assign sample   = toggled && (state == ST_XFER) && !stop;
  assign host_ack = (state == ST_XFER);
  assign crc_valid = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      err_partial <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: if (arm) begin
          state       <= ST_WAIT;
          err_partial <= 1'b0;
        end
        ST_WAIT: if (dev_req) state <= ST_XFER;
        ST_XFER: if (stop) begin
          state       <= ST_DONE;
          err_partial <= mid_block;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  udma_rx_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .toggled (toggled)
  );

  udma_rx_crc #(
    .WORD_W (WORD_W),
    .CRC_W  (16),
    .POLY   (CRC_POLY),
    .SEED   (CRC_SEED)
  ) u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .init   (arm),
    .sample (sample),
    .word   (data_in),
    .crc    (crc_out)
  );

  udma_rx_pack #(
    .WORD_W (WORD_W),
    .WORDS  (WORDS)
  ) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (arm),
    .sample    (sample),
    .word      (data_in),
    .out_ready (blk_ready),
    .out_valid (blk_valid),
    .out_data  (blk_data),
    .mid_block (mid_block),
    .overrun   (err_overrun)
  );

  // R1
  ack_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_ack && !dev_req) |=> !host_ack);

  // R3
  crc_shown_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_valid) |-> $past(stop));

  // R8
  idle_crc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_ack && !start) |=> $stable(crc_out));
endmodule

// File: tb/udma_rx_packer_bench.sv
`timescale 1ns/1ps
module udma_rx_packer_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, stop = 1'b0, dev_req = 1'b0, strobe = 1'b0;
  logic [15:0]  data_in = '0;
  logic         blk_ready = 1'b1;
  logic         host_ack, blk_valid, crc_valid, err_partial, err_overrun;
  logic [127:0] blk_data;
  logic [15:0]  crc_out;

  int checks = 0, fails = 0, blocks_seen = 0, blocks_made = 0;
  logic [127:0] exp_q[$];
  logic [127:0] acc;
  int           acc_n;
  logic [15:0]  exp_crc;
  logic         prev_hs = 1'b0;

  always #10 clk = ~clk;

  udma_rx_packer u_udma_rx_packer (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .dev_req(dev_req),
    .host_ack(host_ack), .strobe(strobe), .data_in(data_in),
    .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_data(blk_data),
    .crc_out(crc_out), .crc_valid(crc_valid), .err_partial(err_partial),
    .err_overrun(err_overrun)
  );

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [15:0] d);
    logic fb;
    for (int i = 15; i >= 0; i--) begin
      fb = c[15] ^ d[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // block monitor: R4 content, R5 single-cycle acceptance
  always @(negedge clk) begin
    if (rst_n && blk_valid && blk_ready) begin
      if (prev_hs) check("R5 valid dropped after accept", 1, 0);
      if (exp_q.size() == 0) check("R4 unexpected block", 1, 0);
      else check("R4 block order", blk_data, exp_q.pop_front());
      blocks_seen++;
      prev_hs <= 1'b1;
    end else prev_hs <= 1'b0;
  end

  // open handshake; strobe changes while waiting must be ignored (R8)
  task automatic open_xfer();
    tick(); start = 1'b1; tick(); start = 1'b0;
    exp_crc = 16'h4ABA; acc = '0; acc_n = 0;
    for (int k = 0; k < 3; k++) begin
      strobe = ~strobe; data_in = 16'($urandom); tick();
    end
    @(negedge clk);
    check("R1 no ack before request", host_ack, 0);
    check("R8 crc untouched while waiting", crc_out, 16'h4ABA);
    tick(); dev_req = 1'b1; tick(); dev_req = 1'b0;
    @(negedge clk);
    check("R1 ack after request", host_ack, 1);
    tick();
  endtask

  task automatic send_word(input logic [15:0] w, input int gap);
    for (int g = 0; g < gap; g++) begin
      data_in = 16'($urandom); tick();
    end
    strobe = ~strobe; data_in = w;
    exp_crc = crc_step(exp_crc, w);
    acc = {acc[111:0], w}; acc_n++;
    if (acc_n == 8) begin exp_q.push_back(acc); acc_n = 0; blocks_made++; end
    tick();
    data_in = 16'($urandom);
  endtask

  task automatic close_xfer();
    stop = 1'b1; tick(); stop = 1'b0;
    @(negedge clk);
    check("R3 crc valid", crc_valid, 1);
    check("R3 crc value", crc_out, exp_crc);
    check("R7 partial flag", err_partial, acc_n != 0);
    check("R1 ack dropped", host_ack, 0);
  endtask

  task automatic run_xfer(input int n, input int gapmax);
    open_xfer();
    for (int i = 0; i < n; i++) send_word(16'($urandom), int'($urandom % (gapmax + 1)));
    close_xfer();
    repeat (3) tick();
  endtask

  initial begin
    #(20 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset ack", host_ack, 0);
    check("R5 reset valid", blk_valid, 0);
    check("R3 reset crc_valid", crc_valid, 0);
    check("R6 reset overrun", err_overrun, 0);

    // empty transfer: seed comes back untouched
    run_xfer(0, 0);

    // back-to-back edges, no gaps, two whole blocks (R2)
    run_xfer(16, 0);
    // random gaps, partial tail (R7)
    run_xfer(11, 2);

    // stop in the same cycle as a strobe change is not captured (R2)
    open_xfer();
    for (int i = 0; i < 5; i++) send_word(16'($urandom), 1);
    strobe = ~strobe; data_in = 16'hDEAD;
    close_xfer();
    check("R2 stop-cycle edge ignored", blocks_seen, blocks_made);
    repeat (3) tick();

    // hold under back-pressure (R5)
    blk_ready = 1'b0;
    run_xfer(8, 1);
    check("R5 valid held", blk_valid, 1);
    check("R5 data held", blk_data, exp_q[0]);
    repeat (4) tick();
    @(negedge clk);
    check("R5 still held", blk_data, exp_q[0]);
    tick(); blk_ready = 1'b1; tick();
    @(negedge clk);
    check("R5 valid cleared after accept", blk_valid, 0);

    // overrun (R6)
    blk_ready = 1'b0;
    run_xfer(16, 0);
    @(negedge clk);
    check("R6 overrun flag", err_overrun, 1);
    check("R6 newer block kept", blk_data, exp_q[1]);
    void'(exp_q.pop_front()); blocks_made--;
    tick(); blk_ready = 1'b1; tick(); tick();
    open_xfer();
    @(negedge clk);
    check("R6 overrun cleared by start", err_overrun, 0);
    close_xfer();
    repeat (3) tick();

    // random transfers
    for (int t = 0; t < 6; t++) run_xfer(1 + int'($urandom % 30), 3);

    repeat (5) tick();
    check("R4 block count", blocks_seen, blocks_made);
    finish_run();
  end
endmodule